// File: doc/BRIEF.md
# Clocked Monostable Pulse Generator

This block is a digital one-shot. It stays idle with its output low. When its trigger input rises, the output goes high for a programmed number of clock cycles and then drops back to idle without further input. The width of the pulse comes only from a cycle count taken from the `pulse_len` input. It does not depend on how long the trigger stays high.

The `retrig` input selects one of two behaviours. In nonretriggerable mode, new trigger edges that arrive while a pulse is running are ignored. In retriggerable mode, each new edge restarts the count, so the pulse lasts a full width measured from the most recent edge. A complementary output is provided for loads that need the active-low form. The trigger is expected to be synchronous to `clk` already.

Top module: `onesh_pulse_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `pulse` low and `pulse_n` high from that edge on, cancelling any pulse in progress and clearing the stored previous trigger value to 0.
- R2: A trigger edge is a clock edge at which `trig` is 1 and `trig` was 0 at the previous edge. An edge seen while idle makes `pulse` high from that same clock edge, so `pulse` is visible high in the following cycle.
- R3: A pulse stays high for exactly N consecutive cycles, where N is `pulse_len` sampled at the edge where the pulse starts. Later changes of `pulse_len` do not change that pulse.
- R4: A `pulse_len` of 0 produces a pulse of exactly one cycle.
- R5: `trig` held high for many cycles produces exactly one pulse. Without a trigger edge, `pulse` never rises.
- R6: With `retrig` = 0 (nonretriggerable), trigger edges during a pulse, other than one in its last high cycle, have no effect on the pulse length.
- R7: With `retrig` = 1 (retriggerable), a trigger edge during a pulse reloads the count. `pulse` then stays high for N cycles after that edge, with N taken from `pulse_len` at the reload.
- R8: A trigger edge that coincides with the last high cycle of a pulse starts a new N-cycle pulse right after it, with no low cycle in between, in both modes.
- R9: `pulse_n` is always the inverse of `pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Trigger line, already synchronous to clk |
| retrig | input | 1 | 0 = nonretriggerable, 1 = retriggerable |
| pulse_len | input | LEN_W | Pulse width in clock cycles (0 is treated as 1) |
| pulse | output | 1 | One-shot output, high while the pulse is active |
| pulse_n | output | 1 | Inverse of pulse |

## Verification
The design has one register stage between a trigger edge and the output. An edge captured at clock edge k therefore shows up as `pulse` high just after edge k. A pulse of width N is low again just after edge k+N. The bench drives `trig` and samples `pulse` on the falling clock edge. A trigger set at falling edge s is therefore expected high from falling edge s+1. Widths are counted as the number of falling-edge samples in which `pulse` is high. Each scheduled second edge is placed at a known offset, including the offset that coincides with the last high cycle (s equal to N) and the one just after it. This lets the bench compute the total high count and the number of rising edges on `pulse` arithmetically for each mode.

// File: rtl/onesh_pkg.sv
package onesh_pkg;

    typedef enum logic {
        MODE_ONCE   = 1'b0,
        MODE_RETRIG = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/onesh_edge.sv
// Rising-edge detector on a synchronous level input.
module onesh_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;

endmodule

// File: rtl/onesh_len_sat.sv
// Maps a programmed length of zero to one cycle.
module onesh_len_sat #(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] len_eff
);

    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(1);

    always_comb begin
        if (len_in == '0) len_eff = LEN_MIN;
        else              len_eff = len_in;
    end

endmodule

// File: rtl/onesh_ctrl.sv
// Idle / active state with a down-counter of remaining high cycles.
module onesh_ctrl
    import onesh_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  trig_mode_e       mode,
    input  logic [LEN_W-1:0] load_len,
    output logic             busy
);

    localparam logic [LEN_W-1:0] LAST = LEN_W'(1);

    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == LAST) begin
                if (rise) begin
                    st_d.cnt = load_len;
                end else begin
                    st_d.busy = 1'b0;
                    st_d.cnt  = '0;
                end
            end else if (rise && mode == MODE_RETRIG) begin
                st_d.cnt = load_len;
            end else begin
                st_d.cnt = st_q.cnt - LAST;
            end
        end else if (rise) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/onesh_pulse_gen.sv
module onesh_pulse_gen
    import onesh_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             retrig,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             pulse,
    output logic             pulse_n
);

    logic             rise;
    logic [LEN_W-1:0] len_eff;
    logic             busy;
    trig_mode_e       mode;

    assign mode = trig_mode_e'(retrig);

    onesh_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (trig),
        .rise  (rise)
    );

    onesh_len_sat #(.LEN_W(LEN_W)) u_len (
        .len_in  (pulse_len),
        .len_eff (len_eff)
    );

    onesh_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .mode     (mode),
        .load_len (len_eff),
        .busy     (busy)
    );

    assign pulse   = busy;
    assign pulse_n = ~busy;

endmodule

// File: rtl/onesh_chk.sv
module onesh_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             trig,
    input logic             retrig,
    input logic [LEN_W-1:0] pulse_len,
    input logic             pulse,
    input logic             pulse_n
);

    logic trig_seen_q;
    logic edge_now;

    always_ff @(posedge clk) begin
        if (rst) trig_seen_q <= 1'b0;
        else     trig_seen_q <= trig;
    end

    assign edge_now = trig & ~trig_seen_q;

    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !pulse);

    // R9
    compl_chk: assert property (@(posedge clk) disable iff (rst) pulse_n == ~pulse);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_now && !pulse) |=> pulse);

    // R2
    cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(edge_now));

    // R5
    no_edge_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!edge_now && !pulse) |=> !pulse);

    // R7
    retrig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && edge_now && retrig) |=> pulse);

    // R8
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && edge_now) |=> pulse);

endmodule

bind onesh_pulse_gen onesh_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_onesh_pulse_gen.sv
`timescale 1ns/1ps
module tb_onesh_pulse_gen;

    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig = 1'b0;
    logic             retrig = 1'b0;
    logic [LEN_W-1:0] pulse_len = '0;
    logic             pulse, pulse_n;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    onesh_pulse_gen #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .trig(trig), .retrig(retrig),
        .pulse_len(pulse_len), .pulse(pulse), .pulse_n(pulse_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One isolated trigger; returns number of high samples.
    task automatic fire(input logic m, input int n, output int w);
        @(negedge clk);
        retrig = m; pulse_len = LEN_W'(n); trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        pulse_len = LEN_W'(n + 7);            // R3: later change ignored
        chk(pulse === 1'b1, "R2", int'(pulse), 1);
        w = 0;
        while (pulse === 1'b1 && w < 400) begin
            chk(pulse_n === ~pulse, "R9", int'(pulse_n), int'(~pulse));
            w++;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // Trigger at sample 0 and at sample t2; counts highs and rises.
    task automatic sched(input logic m, input int n, input int t2,
                         output int highs, output int rises);
        logic last;
        highs = 0; rises = 0; last = 1'b0;
        retrig = m; pulse_len = LEN_W'(n);
        for (int s = 0; s < 40; s++) begin
            @(negedge clk);
            if (pulse === 1'b1) highs++;
            if (pulse === 1'b1 && !last) rises++;
            last = pulse;
            trig = (s == 0 || s == t2);
        end
        trig = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int w, h, r;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pulse === 1'b0, "R1", int'(pulse), 0);
        chk(pulse_n === 1'b1, "R1", int'(pulse_n), 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R5: no trigger, no pulse
        chk(pulse === 1'b0, "R5", int'(pulse), 0);

        // R3 R4: width sweep in both modes
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < 25; n++) begin
                fire(logic'(m), n, w);
                chk(w == ((n == 0) ? 1 : n), (n == 0) ? "R4" : "R3", w, (n == 0) ? 1 : n);
            end
            fire(logic'(m), 255, w);
            chk(w == 255, "R3", w, 255);
        end

        // R5: held trigger gives one pulse
        @(negedge clk);
        retrig = 1'b0; pulse_len = 8'd3; trig = 1'b1;
        h = 0;
        for (int s = 0; s < 20; s++) begin
            @(negedge clk);
            if (pulse === 1'b1) h++;
        end
        chk(h == 3, "R5", h, 3);
        retrig = 1'b1; h = 0;
        for (int s = 0; s < 10; s++) begin
            @(negedge clk);
            if (pulse === 1'b1) h++;
        end
        chk(h == 0, "R5", h, 0);
        trig = 1'b0;
        repeat (3) @(negedge clk);

        // R6: nonretriggerable ignores mid-pulse edge
        sched(1'b0, 10, 4, h, r);
        chk(h == 10, "R6", h, 10);
        chk(r == 1, "R6", r, 1);
        // R7: retriggerable extends from the latest edge
        sched(1'b1, 10, 4, h, r);
        chk(h == 14, "R7", h, 14);
        chk(r == 1, "R7", r, 1);
        // R8: edge in last high cycle, both modes
        for (int m = 0; m < 2; m++) begin
            sched(logic'(m), 5, 5, h, r);
            chk(h == 10, "R8", h, 10);
            chk(r == 1, "R8", r, 1);
        end
        // R6: edge just after the pulse ends gives a separate pulse
        sched(1'b0, 5, 6, h, r);
        chk(h == 10, "R6", h, 10);
        chk(r == 2, "R6", r, 2);

        // R1: reset cancels a running pulse
        @(negedge clk);
        retrig = 1'b0; pulse_len = 8'd20; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (3) @(negedge clk);
        chk(pulse === 1'b1, "R1", int'(pulse), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(pulse === 1'b0, "R1", int'(pulse), 0);
        chk(pulse_n === 1'b1, "R1", int'(pulse_n), 1);
        rst = 1'b0;
        h = 0;
        for (int s = 0; s < 25; s++) begin
            @(negedge clk);
            if (pulse === 1'b1) h++;
        end
        chk(h == 0, "R1", h, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule